// File: doc/BRIEF.md
# Inter-Core Doorbell and Boot Mailbox

This block lets the cores of a small cluster interrupt one another and hand over start-up parameters. Every core owns a private register bank in a shared address window. A sender rings a doorbell by writing ones to the target core's raise word. Those ones collect in the target's pending word. The target reads its pending word and writes the same bits to its acknowledge word to drop them. Each core has an interrupt line. The line is high while any pending bit is also permitted by that core's enable word.

Every bank also holds a mailbox of four 64-bit words: start address, stack pointer, global pointer and a spare word. The bus reaches each one as two 32-bit halves. The word that holds the start address is written last when a core is launched, so a nonzero start address means all parameters are in place. The block drives a per-core `boot_go` output from that word. A launched core writes zero to it when it has come up. A second pending/mask pair exists only as plain storage. The bus is a single-cycle register port: a valid strobe, a write flag, a byte address and 32-bit data. Read data returns one cycle after the request.

Top module: `xipi_doorbell`

## Requirements
- R1: After reset every pending, enable, storage and mailbox word is zero, every `irq` bit is low and every `boot_go` bit is low.
- R2: A write to bank offset 0x08 (raise word) ORs the written ones into that core's pending word. Written zero bits leave pending bits unchanged.
- R3: A write to bank offset 0x0C (acknowledge word) clears the pending bits where the data has ones. The other pending bits are kept.
- R4: `irq[n]` is the OR of (pending AND enable) of core n. It takes its new value in the cycle right after the write that changes either word. Pending bits whose enable bit is 0 do not raise it.
- R5: Core n's bank starts at byte address n*0x100 (address bits [9:8] select the core). An access to one core's bank leaves every other core's state and outputs unchanged.
- R6: Offset 0x04 (enable word) is read/write. Offset 0x00 returns the pending word and is read-only, so writes to it are ignored.
- R7: A read returns its data on `rsp_rdata` with `rsp_valid` high in the cycle after the request. Offsets 0x08, 0x0C, 0x18, 0x1C and any offset at or above 0x40 read as zero, and writes to unmapped offsets change nothing.
- R8: The mailbox holds four 64-bit words at offsets 0x20, 0x28, 0x30 and 0x38. Each is reachable as a low half at +0 and a high half at +4, and reads back what was written.
- R9: `boot_go[n]` is high exactly while the 64-bit mailbox word at 0x20/0x24 of core n is nonzero. It follows a write in the next cycle, and writes to the other mailbox words do not raise it.
- R10: Offset 0x10 (second pending word) and offset 0x14 (second mask word) are plain read/write storage and have no effect on `irq`.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 10 | Byte address: [9:8] core, [7:2] word offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | 32 | Read data |
| irq | output | 4 | Per-core interrupt line |
| boot_go | output | 4 | Per-core launch word nonzero |

## Verification
Writes take effect at the clock edge that samples them. So `irq` and `boot_go` are compared at the falling edge that follows that rising edge, one cycle after the write was driven. Read results are due one cycle after the request. The driver pushes the value a reference model predicts into a queue, and a monitor pops it at the falling edge where `rsp_valid` is high. Reads are spaced two cycles apart, so no valid pulse can be counted twice. Ignored writes are followed at once by reads of the words they might have touched and by a comparison of both output vectors.

// File: rtl/xipi_pkg.sv
package xipi_pkg;
   localparam int REG_W      = 32;
   localparam int BANK_OFS_W = 8;
   localparam int WORD_IDX_W = BANK_OFS_W - 2;

   localparam logic [WORD_IDX_W-1:0] W_PEND  = 6'h00;
   localparam logic [WORD_IDX_W-1:0] W_ENAB  = 6'h01;
   localparam logic [WORD_IDX_W-1:0] W_RAISE = 6'h02;
   localparam logic [WORD_IDX_W-1:0] W_ACK   = 6'h03;
   localparam logic [WORD_IDX_W-1:0] W_PEND2 = 6'h04;
   localparam logic [WORD_IDX_W-1:0] W_MASK2 = 6'h05;
   localparam logic [WORD_IDX_W-1:0] W_MBOX0 = 6'h08;
endpackage

// File: rtl/xipi_bank.sv
module xipi_bank
   import xipi_pkg::*;
#(
   parameter bit IRQ_REG = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hit,
   input  logic                  wr,
   input  logic [WORD_IDX_W-1:0] word,
   input  logic [REG_W-1:0]      wdata,
   output logic [REG_W-1:0]      rdata,
   output logic                  irq
);
   logic [REG_W-1:0] pend_q, enab_q, pend2_q, mask2_q;
   logic [REG_W-1:0] raise_m, ack_m, pend_nxt, enab_nxt;
   logic             wr_hit, raise_hit, ack_hit;

   assign wr_hit    = hit && wr;
   assign raise_hit = wr_hit && (word == W_RAISE);
   assign ack_hit   = wr_hit && (word == W_ACK);
   assign raise_m   = raise_hit ? wdata : '0;
   assign ack_m     = ack_hit ? wdata : '0;
   // raise applied after acknowledge: a simultaneous raise is never lost
   assign pend_nxt  = (pend_q & ~ack_m) | raise_m;
   assign enab_nxt  = (wr_hit && word == W_ENAB) ? wdata : enab_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         enab_q  <= '0;
         pend2_q <= '0;
         mask2_q <= '0;
      end else begin
         pend_q <= pend_nxt;
         enab_q <= enab_nxt;
         if (wr_hit && word == W_PEND2) pend2_q <= wdata;
         if (wr_hit && word == W_MASK2) mask2_q <= wdata;
      end
   end

   generate
      if (IRQ_REG) begin : g_irq_reg
         logic irq_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |(pend_nxt & enab_nxt);
         end
         assign irq = irq_q;

         assert_irq_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
            irq == |(pend_q & enab_q));
      end else begin : g_irq_comb
         assign irq = |(pend_q & enab_q);
      end
   endgenerate

   always_comb begin
      case (word)
         W_PEND:  rdata = pend_q;
         W_ENAB:  rdata = enab_q;
         W_PEND2: rdata = pend2_q;
         W_MASK2: rdata = mask2_q;
         default: rdata = '0;
      endcase
   end

   assert_raise_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
      raise_hit |=> ((pend_q & $past(wdata)) == $past(wdata)));
   assert_ack_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_hit && !raise_hit) |=> ((pend_q & $past(wdata)) == '0));
   assert_pend_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(raise_hit || ack_hit) |=> $stable(pend_q));
endmodule

// File: rtl/xipi_mbox.sv
module xipi_mbox
   import xipi_pkg::*;
#(
   parameter int MBOX_WORDS = 4
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  hit,
   input  logic                  wr,
   input  logic [WORD_IDX_W-1:0] word,
   input  logic [REG_W-1:0]      wdata,
   output logic [REG_W-1:0]      rdata,
   output logic                  boot_go
);
   localparam int HALVES     = 2 * MBOX_WORDS;
   localparam int HALF_IDX_W = $clog2(HALVES);
   localparam int BASE       = int'(W_MBOX0);

   logic [REG_W-1:0]      half_q [HALVES];
   logic [WORD_IDX_W-1:0] rel;
   logic                  in_range;

   assign rel      = word - W_MBOX0;
   assign in_range = (int'(word) >= BASE) && (int'(word) < BASE + HALVES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int k = 0; k < HALVES; k++) half_q[k] <= '0;
      end else if (hit && wr && in_range) begin
         half_q[rel[HALF_IDX_W-1:0]] <= wdata;
      end
   end

   assign rdata   = in_range ? half_q[rel[HALF_IDX_W-1:0]] : '0;
   assign boot_go = |{half_q[1], half_q[0]};

   assert_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr && word == W_MBOX0 && wdata != '0) |=> boot_go);
   assert_other_no_launch_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && wr && in_range && int'(word) > BASE + 1 && !boot_go) |=> !boot_go);
endmodule

// File: rtl/xipi_doorbell.sv
module xipi_doorbell
   import xipi_pkg::*;
#(
   parameter int NUM_CORES  = 4,
   parameter int MBOX_WORDS = 4,
   parameter bit IRQ_REG    = 1'b1,
   localparam int CORE_W    = $clog2(NUM_CORES),
   localparam int ADDR_W    = CORE_W + BANK_OFS_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [REG_W-1:0]     req_wdata,
   output logic                 rsp_valid,
   output logic [REG_W-1:0]     rsp_rdata,
   output logic [NUM_CORES-1:0] irq,
   output logic [NUM_CORES-1:0] boot_go
);
   generate
      if (NUM_CORES < 2) begin : g_bad_cores
         $error("NUM_CORES must be at least 2");
      end
      if (MBOX_WORDS < 1 || 8 + 2 * MBOX_WORDS > 16) begin : g_bad_mbox
         $error("MBOX_WORDS must be 1..4 to fit below offset 0x40");
      end
   endgenerate

   logic [CORE_W-1:0]     core_idx;
   logic [WORD_IDX_W-1:0] word;
   logic [REG_W-1:0]      bank_rd [NUM_CORES];
   logic [REG_W-1:0]      mb_rd   [NUM_CORES];
   logic [REG_W-1:0]      rd_sel;

   assign core_idx = req_addr[ADDR_W-1:BANK_OFS_W];
   assign word     = req_addr[BANK_OFS_W-1:2];

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
         logic sel;
         assign sel = req_valid && (core_idx == CORE_W'(c));

         xipi_bank #(.IRQ_REG(IRQ_REG)) u_bank (
            .clk(clk), .rst_n(rst_n), .hit(sel), .wr(req_write),
            .word(word), .wdata(req_wdata), .rdata(bank_rd[c]), .irq(irq[c])
         );

         xipi_mbox #(.MBOX_WORDS(MBOX_WORDS)) u_mbox (
            .clk(clk), .rst_n(rst_n), .hit(sel), .wr(req_write),
            .word(word), .wdata(req_wdata), .rdata(mb_rd[c]), .boot_go(boot_go[c])
         );
      end
   endgenerate

   always_comb begin
      rd_sel = '0;
      for (int c = 0; c < NUM_CORES; c++)
         if (core_idx == CORE_W'(c)) rd_sel = bank_rd[c] | mb_rd[c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid && !req_write;
         if (req_valid && !req_write) rsp_rdata <= rd_sel;
      end
   end

   assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write) |=> rsp_valid);
   assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && word >= 6'h10) |=> ($stable(irq) && $stable(boot_go)));
endmodule

// File: tb/xipi_doorbell_test.sv
module xipi_doorbell_test;
   localparam int NC = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [9:0]  req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        rsp_valid;
   logic [31:0] rsp_rdata;
   logic [NC-1:0] irq, boot_go;

   int checks = 0, fails = 0;

   logic [31:0] m_pend [NC], m_en [NC], m_p2 [NC], m_m2 [NC];
   logic [31:0] m_mb [NC][8];

   logic [31:0] exp_q [$];
   string       tag_q [$];

   always #10 clk = ~clk;

   xipi_doorbell uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
      .rsp_rdata(rsp_rdata), .irq(irq), .boot_go(boot_go)
   );

   function automatic logic [31:0] model_rd(int c, int ofs);
      case (ofs)
         'h00: return m_pend[c];
         'h04: return m_en[c];
         'h10: return m_p2[c];
         'h14: return m_m2[c];
         default: if (ofs >= 'h20 && ofs < 'h40) return m_mb[c][(ofs - 'h20) / 4];
      endcase
      return 32'h0;
   endfunction

   task automatic model_wr(int c, int ofs, logic [31:0] d);
      case (ofs)
         'h04: m_en[c] = d;
         'h08: m_pend[c] = m_pend[c] | d;
         'h0C: m_pend[c] = m_pend[c] & ~d;
         'h10: m_p2[c] = d;
         'h14: m_m2[c] = d;
         default: if (ofs >= 'h20 && ofs < 'h40) m_mb[c][(ofs - 'h20) / 4] = d;
      endcase
   endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_outs(string req);
      logic [NC-1:0] ei, eb;
      for (int c = 0; c < NC; c++) begin
         ei[c] = |(m_pend[c] & m_en[c]);
         eb[c] = |{m_mb[c][1], m_mb[c][0]};
      end
      check({req, " irq"}, 32'(irq), 32'(ei));
      check({req, " boot_go"}, 32'(boot_go), 32'(eb));
   endtask

   // outputs sampled at the falling edge after the capturing rising edge
   task automatic wr(int c, int ofs, logic [31:0] d, string req);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1;
      req_addr = 10'(c * 'h100 + ofs); req_wdata = d;
      model_wr(c, ofs, d);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
      check_outs(req);
   endtask

   task automatic rd(int c, int ofs, string req);
      @(negedge clk);
      exp_q.push_back(model_rd(c, ofs));
      tag_q.push_back(req);
      req_valid = 1'b1; req_write = 1'b0;
      req_addr = 10'(c * 'h100 + ofs);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // monitor: each read result is due one cycle after the request
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (exp_q.size() == 0) begin
            checks++; fails++;
            $display("FAIL R7: unexpected rsp_valid, actual %h expected none", rsp_rdata);
         end else begin
            string t;
            logic [31:0] e;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(t, rsp_rdata, e);
         end
      end
   end

   initial begin
      #4_000_000;
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < NC; c++) begin
         m_pend[c] = '0; m_en[c] = '0; m_p2[c] = '0; m_m2[c] = '0;
         for (int k = 0; k < 8; k++) m_mb[c][k] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_outs("R1");
      for (int c = 0; c < NC; c++) begin
         rd(c, 'h00, "R1 pend");
         rd(c, 'h04, "R1 enable");
         rd(c, 'h20, "R1 mailbox");
      end

      wr(1, 'h04, 32'h0000_00FF, "R6 enable write");
      rd(1, 'h04, "R6 enable read");
      wr(1, 'h00, 32'hFFFF_FFFF, "R6 pend read-only");
      rd(1, 'h00, "R6 pend unchanged");

      wr(1, 'h08, 32'h0000_0005, "R2 R4 raise");
      rd(1, 'h00, "R2 pend");
      rd(0, 'h00, "R5 core0 untouched");
      wr(1, 'h08, 32'h0000_0030, "R2 raise accumulates");
      rd(1, 'h00, "R2 pend or");
      wr(1, 'h0C, 32'h0000_0005, "R3 partial ack");
      rd(1, 'h00, "R3 pend kept");
      wr(1, 'h0C, 32'h0000_0030, "R3 R4 full ack");
      rd(1, 'h00, "R3 pend empty");
      wr(1, 'h08, 32'h0000_0100, "R4 masked pend");
      wr(1, 'h04, 32'h0000_0100, "R4 enable late");
      wr(1, 'h04, 32'h0000_0000, "R4 disable");

      rd(1, 'h08, "R7 raise reads zero");
      rd(1, 'h0C, "R7 ack reads zero");
      rd(1, 'h18, "R7 set2 reads zero");
      rd(1, 'h1C, "R7 clr2 reads zero");
      wr(1, 'h40, 32'hDEAD_BEEF, "R7 unmapped write");
      rd(1, 'h40, "R7 unmapped read");
      rd(1, 'h00, "R7 pend after unmapped");
      wr(1, 'h18, 32'hFFFF_FFFF, "R10 set2 ignored");
      rd(1, 'h00, "R10 pend after set2");

      wr(2, 'h10, 32'hA5A5_0001, "R10 pend2");
      wr(2, 'h14, 32'hFFFF_FFFF, "R10 mask2");
      rd(2, 'h10, "R10 pend2 read");
      rd(2, 'h14, "R10 mask2 read");

      wr(2, 'h38, 32'h0000_0000, "R9 spare lo");
      wr(2, 'h3C, 32'h1111_2222, "R9 spare hi");
      wr(2, 'h30, 32'h3333_4444, "R9 gp");
      wr(2, 'h28, 32'h5555_6666, "R9 sp");
      wr(2, 'h20, 32'h8000_1000, "R9 pc launch");
      for (int o = 'h20; o < 'h40; o += 4) rd(2, o, "R8 mailbox readback");
      wr(2, 'h20, 32'h0000_0000, "R9 pc zero");
      wr(2, 'h24, 32'h0000_0001, "R9 pc high half");
      wr(2, 'h24, 32'h0000_0000, "R9 done");

      wr(3, 'h04, 32'h8000_0000, "R5 core3 enable");
      wr(3, 'h08, 32'h8000_0000, "R5 core3 raise");
      rd(3, 'h00, "R5 core3 pend");
      rd(1, 'h00, "R5 core1 pend");
      wr(3, 'h0C, 32'hFFFF_FFFF, "R3 core3 ack all");

      repeat (3) @(negedge clk);
      if (exp_q.size() != 0) begin
         checks++; fails++;
         $display("FAIL R7: actual %0d reads unanswered expected 0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule